// File: doc/BRIEF.md
# BF16 Widening Multiply-Accumulate Lanes

This block is a 128-bit SIMD arithmetic slice. Two source vectors each carry eight BF16 values, and an accumulator vector carries four FP32 values. A single select input decides which BF16 element of each adjacent pair feeds each output lane: the lower-indexed one or the higher-indexed one. Each chosen pair of BF16 operands is widened to FP32 exactly and multiplied. The product is then added to the matching FP32 accumulator lane with no intermediate rounding, and the sum is rounded once to FP32 with round-to-nearest-even.

Subnormal operands are read as signed zeros. A result too small to be a normal FP32 number is flushed to a signed zero. NaN and invalid operations give one canonical quiet NaN. All four lanes work in parallel. The results sit in an output register and come with a valid strobe one clock after the request. When no request arrives, the register keeps its last value.

Top module: `bf16_fma_lanes`

## Requirements
- R1: Output lane e reads BF16 element 2e when `hi_sel` is 0, and element 2e+1 when `hi_sel` is 1, from both `src_a` and `src_b`. Element k occupies bits [16k+15:16k]. The element that is not selected has no effect on the result.
- R2: The addend for lane e is `acc_in` bits [32e+31:32e]. The result of lane e is written to `result` bits [32e+31:32e].
- R3: Each lane returns the exact value a*b+c rounded once to FP32, using round-to-nearest, ties-to-even.
- R4: Any operand whose exponent field is zero is treated as a zero of the same sign. This holds for the BF16 exponent (bits 14:7) and for the FP32 exponent (bits 30:23).
- R5: If the rounded result has a magnitude below 2^-126, the lane returns a zero with the sign of the exact result. No output ever has a zero exponent with a nonzero fraction.
- R6: If any of the three operands is a NaN, the lane returns 0x7FC00000. This is also the only NaN pattern the block ever outputs.
- R7: Infinity times zero, or an infinite product added to an infinite addend of the opposite sign, returns 0x7FC00000. Any other case with an infinite operand returns an infinity with the IEEE sign.
- R8: If the rounded result exceeds the largest finite FP32 value, the lane returns an infinity with the sign of the result.
- R9: An exact zero sum is +0. The exception is when the product and the addend are both zeros of the same sign; then that signed zero is returned.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` changes only after a cycle with `in_valid` high, and holds its value otherwise.
- R11: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled on this edge |
| hi_sel | input | 1 | 0 picks even BF16 elements, 1 picks odd ones |
| src_a | input | 128 | First source vector, eight BF16 elements |
| src_b | input | 128 | Second source vector, eight BF16 elements |
| acc_in | input | 128 | Accumulator vector, four FP32 lanes |
| out_valid | output | 1 | High one cycle after an accepted request |
| result | output | 128 | Four FP32 results, registered |

## Verification
Within a single cycle, the element selection and the special-value handling act together. A lane can take a NaN, an infinity or a flushed subnormal from the selected element while the element beside it holds an ordinary number, and the other lanes compute normal sums in the same issue. The bench fills every unselected element with random data and sends requests back to back with `hi_sel` flipping, so each request is registered in the same edge where the previous result is still visible. Every lane is compared on every clock against an independent double-precision model. That model repairs double rounding with an exact error term. Directed cases also carry hard-coded expected words for rounding ties, flushing, overflow and signed zeros.

// File: rtl/bfma_pkg.sv
package bfma_pkg;
  localparam int BF_W = 16;
  localparam int SP_W = 32;
  localparam logic [31:0] SP_QNAN = 32'h7FC0_0000;
  localparam logic [7:0]  SP_EXP_ALL = 8'hFF;
endpackage

// File: rtl/bfma_pick.sv
module bfma_pick
  import bfma_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      odd_sel,
  input  logic [2*LANES*BF_W-1:0]   vec_in,
  output logic [LANES*BF_W-1:0]     picked
);
  for (genvar e = 0; e < LANES; e++) begin : g_pick
    assign picked[e*BF_W +: BF_W] = odd_sel ? vec_in[(2*e+1)*BF_W +: BF_W]
                                            : vec_in[(2*e)*BF_W +: BF_W];
  end
endmodule

// File: rtl/bfma_lane.sv
module bfma_lane
  import bfma_pkg::*;
#(
  parameter int GUARD = 32
) (
  input  logic [BF_W-1:0] op_a,
  input  logic [BF_W-1:0] op_b,
  input  logic [SP_W-1:0] addend,
  output logic [SP_W-1:0] sum
);
  localparam int MW = 48;             // aligned significand width
  localparam int FW = MW + GUARD + 1; // field width incl. carry bit

  logic a_zero, a_inf, a_nan, b_zero, b_inf, b_nan, c_zero, c_inf, c_nan;
  logic p_sgn, c_sgn, big_is_p, big_sgn, small_sgn, r_sgn, inc;
  logic [15:0] p_mag;
  logic [MW-1:0] p_wide, c_wide;
  logic [FW-1:0] big_f, small_f, aligned, mag, norm;
  logic [23:0] mant;
  logic [24:0] m_rnd;
  logic [22:0] frac;
  logic guard_b, stk, jam;
  int p_exp, c_exp, big_exp, shamt, lead, rexp;

  assign a_zero = (op_a[14:7] == 8'd0);
  assign b_zero = (op_b[14:7] == 8'd0);
  assign c_zero = (addend[30:23] == 8'd0);
  assign a_inf  = (&op_a[14:7]) & ~(|op_a[6:0]);
  assign b_inf  = (&op_b[14:7]) & ~(|op_b[6:0]);
  assign c_inf  = (&addend[30:23]) & ~(|addend[22:0]);
  assign a_nan  = (&op_a[14:7]) & (|op_a[6:0]);
  assign b_nan  = (&op_b[14:7]) & (|op_b[6:0]);
  assign c_nan  = (&addend[30:23]) & (|addend[22:0]);
  assign p_sgn  = op_a[15] ^ op_b[15];
  assign c_sgn  = addend[31];
  assign p_mag  = {1'b1, op_a[6:0]} * {1'b1, op_b[6:0]};

  // exact alignment, jammed sticky, single add
  always_comb begin
    p_exp    = int'(op_a[14:7]) + int'(op_b[14:7]) - 300;
    c_exp    = int'(addend[30:23]) - 174;
    p_wide   = {p_mag, 32'b0};
    c_wide   = {1'b1, addend[22:0], 24'b0};
    big_is_p = c_zero | (p_exp >= c_exp);
    big_exp  = big_is_p ? p_exp : c_exp;
    shamt    = big_is_p ? (p_exp - c_exp) : (c_exp - p_exp);
    big_sgn  = big_is_p ? p_sgn : c_sgn;
    small_sgn = big_is_p ? c_sgn : p_sgn;
    big_f    = {1'b0, (big_is_p ? p_wide : c_wide), {GUARD{1'b0}}};
    small_f  = c_zero ? '0 : {1'b0, (big_is_p ? c_wide : p_wide), {GUARD{1'b0}}};
    if (shamt >= FW) begin
      aligned = '0;
      jam     = |small_f;
    end else begin
      aligned = small_f >> shamt;
      jam     = |(small_f & ~({FW{1'b1}} << shamt));
    end
    aligned = aligned | {{(FW-1){1'b0}}, jam};
    if (p_sgn == c_sgn || c_zero) begin
      mag   = big_f + aligned;
      r_sgn = big_sgn;
    end else if (big_f >= aligned) begin
      mag   = big_f - aligned;
      r_sgn = big_sgn;
    end else begin
      mag   = aligned - big_f;
      r_sgn = small_sgn;
    end
    lead = 0;
    for (int i = 0; i < FW; i++) if (mag[i]) lead = i;
    norm    = mag << (FW - 1 - lead);
    mant    = norm[FW-1 -: 24];
    guard_b = norm[FW-25];
    stk     = |norm[FW-26:0];
    inc     = guard_b & (stk | mant[0]);
    m_rnd   = {1'b0, mant} + {24'b0, inc};
    rexp    = lead + big_exp + 127 - GUARD;
    if (m_rnd[24]) begin
      rexp = rexp + 1;
      frac = 23'b0;
    end else begin
      frac = m_rnd[22:0];
    end
  end

  // special-value priority and final packing
  always_comb begin
    if (a_nan | b_nan | c_nan | (a_inf & b_zero) | (b_inf & a_zero) |
        ((a_inf | b_inf) & c_inf & (p_sgn != c_sgn)))
      sum = SP_QNAN;
    else if (a_inf | b_inf)
      sum = {p_sgn, SP_EXP_ALL, 23'b0};
    else if (c_inf)
      sum = {c_sgn, SP_EXP_ALL, 23'b0};
    else if ((a_zero | b_zero) & c_zero)
      sum = {p_sgn & c_sgn, 31'b0};
    else if (a_zero | b_zero)
      sum = addend;
    else if (mag == '0)
      sum = '0;
    else if (rexp >= 255)
      sum = {r_sgn, SP_EXP_ALL, 23'b0};
    else if (rexp <= 0)
      sum = {r_sgn, 31'b0};
    else
      sum = {r_sgn, 8'(rexp), frac};
  end

  always_comb begin
    // R5: the normal path never emits an unflushed subnormal
    assert ((sum[30:23] != 8'd0) || (sum[22:0] == 23'd0))
      else $error("p_lane_ftz_r5");
  end
endmodule

// File: rtl/bf16_fma_lanes.sv
module bf16_fma_lanes
  import bfma_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             hi_sel,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int LANES = VEC_W / SP_W;

  logic [LANES*BF_W-1:0] pk_a, pk_b;
  logic [VEC_W-1:0]      lane_sum;

  bfma_pick #(.LANES(LANES)) i_pick_a (.odd_sel(hi_sel), .vec_in(src_a), .picked(pk_a));
  bfma_pick #(.LANES(LANES)) i_pick_b (.odd_sel(hi_sel), .vec_in(src_b), .picked(pk_b));

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    bfma_lane i_lane (
      .op_a   (pk_a[e*BF_W +: BF_W]),
      .op_b   (pk_b[e*BF_W +: BF_W]),
      .addend (acc_in[e*SP_W +: SP_W]),
      .sum    (lane_sum[e*SP_W +: SP_W])
    );

    p_nan_in_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid && (&pk_a[e*BF_W+7 +: 8]) && (|pk_a[e*BF_W +: 7])
      |=> result[e*SP_W +: SP_W] == SP_QNAN);

    p_nan_canon_r6: assert property (@(posedge clk) disable iff (rst)
      (&result[e*SP_W+23 +: 8]) && (|result[e*SP_W +: 23])
      |-> result[e*SP_W +: SP_W] == SP_QNAN);

    p_no_subnormal_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (result[e*SP_W+23 +: 8] != 8'd0) || (result[e*SP_W +: 23] == 23'd0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= lane_sum;
    end
  end

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

// File: tb/test_bf16_fma_lanes.sv
`timescale 1ns/1ps
module test_bf16_fma_lanes;
  logic clk = 1'b0;
  logic rst, in_valid, hi_sel;
  logic [127:0] src_a, src_b, acc_in, result;
  logic out_valid;
  int n_checks = 0, n_fail = 0;
  logic exp_valid;
  logic [127:0] exp_res;

  always #2.5 clk = ~clk;

  bf16_fma_lanes i_bf16_fma_lanes (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hi_sel(hi_sel),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .result(result));

  function automatic real bf_real(logic [15:0] h);
    logic [10:0] de;
    if (h[14:7] == 8'd0) return $bitstoreal({h[15], 63'b0});
    de = {3'b0, h[14:7]} + 11'd896;
    return $bitstoreal({h[15], de, h[6:0], 45'b0});
  endfunction

  function automatic real sp_real(logic [31:0] w);
    logic [10:0] de;
    if (w[30:23] == 8'd0) return $bitstoreal({w[31], 63'b0});
    de = {3'b0, w[30:23]} + 11'd896;
    return $bitstoreal({w[31], de, w[22:0], 29'b0});
  endfunction

  // independent model: double arithmetic, exact error term, own rounding
  function automatic logic [31:0] model(logic [15:0] a, logic [15:0] b, logic [31:0] c);
    logic an, bn, cn, ai, bi, ci, az, bz, ps, inc;
    real p, rc, s, bb, err;
    logic [63:0] bits;
    logic [23:0] m;
    logic [24:0] m25;
    int be;
    an = (a[14:7] == 8'hFF) && (a[6:0] != 0);
    bn = (b[14:7] == 8'hFF) && (b[6:0] != 0);
    cn = (c[30:23] == 8'hFF) && (c[22:0] != 0);
    ai = (a[14:7] == 8'hFF) && (a[6:0] == 0);
    bi = (b[14:7] == 8'hFF) && (b[6:0] == 0);
    ci = (c[30:23] == 8'hFF) && (c[22:0] == 0);
    az = (a[14:7] == 0);
    bz = (b[14:7] == 0);
    ps = a[15] ^ b[15];
    if (an || bn || cn) return 32'h7FC00000;
    if ((ai && bz) || (bi && az)) return 32'h7FC00000;
    if ((ai || bi) && ci && (ps != c[31])) return 32'h7FC00000;
    if (ai || bi) return {ps, 8'hFF, 23'b0};
    if (ci) return {c[31], 8'hFF, 23'b0};
    p  = bf_real(a) * bf_real(b);
    rc = sp_real(c);
    s  = p + rc;
    bb = s - p;
    err = (p - (s - bb)) + (rc - bb);
    bits = $realtobits(s);
    if (s == 0.0) return {bits[63], 31'b0};
    m = {1'b1, bits[51:29]};
    if (err != 0.0 && bits[28] && bits[27:0] == 0)
      inc = ((err > 0.0) == (s > 0.0));
    else
      inc = bits[28] && ((bits[27:0] != 0) || (err != 0.0) || m[0]);
    m25 = {1'b0, m} + {24'b0, inc};
    be = int'(bits[62:52]) - 1023 + 127;
    if (m25[24]) be = be + 1;
    if (be >= 255) return {bits[63], 8'hFF, 23'b0};
    if (be <= 0) return {bits[63], 31'b0};
    return {bits[63], 8'(be), (m25[24] ? 23'b0 : m25[22:0])};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cycle(string tag, logic v, logic sel,
                       logic [127:0] a, logic [127:0] b, logic [127:0] c);
    in_valid = v; hi_sel = sel; src_a = a; src_b = b; acc_in = c;
    @(posedge clk);
    if (rst) begin
      exp_valid = 1'b0;
      exp_res   = '0;
    end else begin
      exp_valid = v;
      if (v)
        for (int e = 0; e < 4; e++)
          exp_res[32*e +: 32] = model(a[16*(2*e+sel) +: 16], b[16*(2*e+sel) +: 16],
                                      c[32*e +: 32]);
    end
    @(negedge clk);
    chk(rst ? "R11" : "R10", "out_valid", {31'b0, out_valid}, {31'b0, exp_valid});
    for (int e = 0; e < 4; e++)
      chk(tag, $sformatf("lane %0d", e), result[32*e +: 32], exp_res[32*e +: 32]);
  endtask

  function automatic logic [15:0] near_bf();
    return {1'($urandom), 8'(120 + $urandom % 16), 7'($urandom)};
  endfunction

  function automatic logic [31:0] near_sp();
    return {1'($urandom), 8'(118 + $urandom % 20), 23'($urandom)};
  endfunction

  // same triple in every selected slot, random data in the unselected slots
  task automatic dir(string tag, logic sel, logic [15:0] a, logic [15:0] b,
                     logic [31:0] c, logic [31:0] want);
    logic [127:0] va, vb, vc;
    for (int k = 0; k < 8; k++) begin
      va[16*k +: 16] = (k % 2 == int'(sel)) ? a : 16'($urandom);
      vb[16*k +: 16] = (k % 2 == int'(sel)) ? b : 16'($urandom);
    end
    for (int e = 0; e < 4; e++) vc[32*e +: 32] = c;
    cycle(tag, 1'b1, sel, va, vb, vc);
    for (int e = 0; e < 4; e++)
      chk(tag, "fixed", result[32*e +: 32], want);
  endtask

  task automatic rnd(string tag, logic v, logic sel, bit wide);
    logic [127:0] va, vb, vc;
    for (int k = 0; k < 8; k++) begin
      va[16*k +: 16] = wide ? 16'($urandom) : near_bf();
      vb[16*k +: 16] = wide ? 16'($urandom) : near_bf();
    end
    for (int e = 0; e < 4; e++) vc[32*e +: 32] = wide ? $urandom : near_sp();
    cycle(tag, v, sel, va, vb, vc);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    exp_valid = 1'b0;
    exp_res = '0;
    rst = 1'b1;
    @(negedge clk);
    // R11: reset dominates an active request
    for (int i = 0; i < 3; i++) rnd("R11", 1'b1, 1'(i), 1'b0);
    rst = 1'b0;

    // R3: single rounding at a tie and just above it
    dir("R3", 1'b0, 16'h3380, 16'h3F80, 32'h3F800000, 32'h3F800000);
    dir("R3", 1'b1, 16'h3381, 16'h3F80, 32'h3F800000, 32'h3F800001);
    dir("R3", 1'b0, 16'h4040, 16'h4000, 32'h3F800000, 32'h40E00000);
    // R4: subnormal operands act as signed zeros
    dir("R4", 1'b1, 16'h0001, 16'h3F80, 32'h80000000, 32'h00000000);
    dir("R4", 1'b0, 16'h3F80, 16'h3F80, 32'h00000005, 32'h3F800000);
    // R5: tiny results flush to signed zero
    dir("R5", 1'b0, 16'h0080, 16'h3F00, 32'h00000000, 32'h00000000);
    dir("R5", 1'b1, 16'h0080, 16'hBF00, 32'h00000000, 32'h80000000);
    // R6: NaN operands give the canonical quiet NaN
    dir("R6", 1'b1, 16'h7FC1, 16'h3F80, 32'h3F800000, 32'h7FC00000);
    dir("R6", 1'b0, 16'h3F80, 16'h3F80, 32'h7F800001, 32'h7FC00000);
    // R7: invalid infinity cases and signed infinities
    dir("R7", 1'b0, 16'h7F80, 16'h0000, 32'h00000000, 32'h7FC00000);
    dir("R7", 1'b1, 16'h7F80, 16'h3F80, 32'hFF800000, 32'h7FC00000);
    dir("R7", 1'b0, 16'h7F80, 16'hBF80, 32'h3F800000, 32'hFF800000);
    // R8: overflow to signed infinity
    dir("R8", 1'b1, 16'h7F7F, 16'h7F7F, 32'h00000000, 32'h7F800000);
    dir("R8", 1'b0, 16'h7F7F, 16'hFF7F, 32'h3F800000, 32'hFF800000);
    // R9: zero sign rules
    dir("R9", 1'b0, 16'h8000, 16'h3F80, 32'h00000000, 32'h00000000);
    dir("R9", 1'b1, 16'h8000, 16'h3F80, 32'h80000000, 32'h80000000);
    dir("R9", 1'b0, 16'h3F80, 16'h3F80, 32'hBF800000, 32'h00000000);

    // R10: idle cycles keep the result and drop valid
    rnd("R10", 1'b0, 1'b0, 1'b0);
    rnd("R10", 1'b0, 1'b1, 1'b1);

    // R1 / R2: back-to-back issue with alternating selection, per-lane addends
    for (int i = 0; i < 300; i++) rnd("R1", 1'b1, 1'(i), 1'b0);
    for (int i = 0; i < 300; i++) rnd("R2", 1'($urandom), 1'($urandom), 1'b1);
    for (int i = 0; i < 300; i++) rnd("R3", 1'b1, 1'($urandom), 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule